// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupts

A bank of general-purpose pins under a word-wide register bus. For each pin the block settles a single level from three candidates, in priority order: an external agent that currently claims the pin, the block's own output driver, and finally the pull setting as the idle level. That level is gated by the pin's input enable and sampled into a read-only sample register. Four sticky event flags per pin follow the sample: level high, level low, rising change, falling change. Each flag has its own enable mask, and every pin has its own interrupt line.

Software configures the pins with plain writes and acknowledges events by writing ones to the flag registers. External level and claim inputs cross into the clock domain through a two-stage synchronizer before they take part in the level choice. The drive-strength and alternate-function registers only hold their value.

Top module: `gpio_ctrl`

## Requirements
- R1: A pin that is not externally claimed and has its output enabled shows the level (output value XOR invert bit) on `pad_level_o`.
- R2: The synchronized external claim wins over the output driver. A pin with neither a claim nor an enabled output shows its pull bit.
- R3: `ext_lvl_i` and `ext_drv_i` reach `pad_level_o` two clock edges after they change. The sample register (offset 0x00) holds input-enable AND pad level, one edge later.
- R4: The high flag of a pin sets whenever the new sample is 1. The low flag sets whenever the new sample is 0, also with input disabled, so all low flags are set one edge after reset. The flags stay set until cleared.
- R5: The rise flag sets when the new sample is 1 and the stored sample is 0. The fall flag sets in the opposite case.
- R6: A write to a flag register (rise 0x1C, fall 0x24, high 0x2C, low 0x34) clears exactly the bits written as 1. A flag whose set condition holds in the same cycle stays set.
- R7: `irq_o[i]` is high while any of the four flags of pin i is set together with its enable bit (rise 0x18, fall 0x20, high 0x28, low 0x30).
- R8: While reset is active, every register reads 0 and `irq_o` is 0.
- R9: Byte offsets: sample 0x00, input enable 0x04, output enable 0x08, output value 0x0C, pull 0x10, strength 0x14, invert 0x40. Any other address (including 0x44 and unaligned ones) reads 0, and writes to it change nothing.
- R10: Strength 0x14, alt enable 0x38 and alt select 0x3C read back what was written and have no effect on `pad_level_o`.
- R11: Writes to the sample register 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 7 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register, combinational |
| ext_lvl_i | input | 32 | Level driven by an external agent, per pin |
| ext_drv_i | input | 32 | Per-pin flag: an external agent claims the pin |
| pad_level_o | output | 32 | Resolved level of each pin |
| irq_o | output | 32 | Interrupt line per pin |

## Verification
A write-one-to-clear of a flag can land on the same edge on which that flag's set condition holds again. The low flag of a pin whose sample stays 0 is the case that always repeats. The bench provokes this on purpose by clearing the low flag of a pin that is held low. It also provokes it at random, with synchronized input changes mixed with random clear writes. The judgement is that the set wins, checked both by a directed read-back and by the cycle reference model on every clock.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SAMPLE    = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_IN_EN     = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_DRV_EN    = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_DRV_VAL   = 7'h0C;
  localparam logic [ADDR_W-1:0] OFF_PULL      = 7'h10;
  localparam logic [ADDR_W-1:0] OFF_STRENGTH  = 7'h14;
  localparam logic [ADDR_W-1:0] OFF_RISE_EN   = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_RISE_PEND = 7'h1C;
  localparam logic [ADDR_W-1:0] OFF_FALL_EN   = 7'h20;
  localparam logic [ADDR_W-1:0] OFF_FALL_PEND = 7'h24;
  localparam logic [ADDR_W-1:0] OFF_HI_EN     = 7'h28;
  localparam logic [ADDR_W-1:0] OFF_HI_PEND   = 7'h2C;
  localparam logic [ADDR_W-1:0] OFF_LO_EN     = 7'h30;
  localparam logic [ADDR_W-1:0] OFF_LO_PEND   = 7'h34;
  localparam logic [ADDR_W-1:0] OFF_ALT_EN    = 7'h38;
  localparam logic [ADDR_W-1:0] OFF_ALT_SEL   = 7'h3C;
  localparam logic [ADDR_W-1:0] OFF_DRV_INV   = 7'h40;

  // event index within a pin slice
  localparam int unsigned EV_HI   = 0;
  localparam int unsigned EV_LO   = 1;
  localparam int unsigned EV_RISE = 2;
  localparam int unsigned EV_FALL = 3;
  localparam int unsigned N_EV    = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_drv_i,
  input  logic            ext_lvl_i,
  input  logic            in_en_i,
  input  logic            drv_en_i,
  input  logic            drv_val_i,
  input  logic            drv_inv_i,
  input  logic            pull_en_i,
  input  logic [N_EV-1:0] clr_i,
  input  logic [N_EV-1:0] ev_en_i,
  output logic            level_o,
  output logic            sample_o,
  output logic [N_EV-1:0] pend_o,
  output logic            irq_o
);
  logic            sample_q, sample_d, own_lvl;
  logic [N_EV-1:0] pend_q, hit;

  always_comb begin
    own_lvl = drv_en_i & (drv_val_i ^ drv_inv_i);
    // external claim outranks own driver; pull is the idle level
    if (ext_drv_i)     level_o = ext_lvl_i;
    else if (drv_en_i) level_o = own_lvl;
    else               level_o = pull_en_i;
    sample_d      = in_en_i & level_o;
    hit[EV_HI]    = sample_d;
    hit[EV_LO]    = ~sample_d;
    hit[EV_RISE]  = sample_d & ~sample_q;
    hit[EV_FALL]  = ~sample_d & sample_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      pend_q   <= '0;
    end else begin
      sample_q <= sample_d;
      pend_q   <= (pend_q & ~clr_i) | hit;  // set beats clear
    end
  end

  assign sample_o = sample_q;
  assign pend_o   = pend_q;
  assign irq_o    = |(pend_q & ev_en_i);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] ext_lvl_i,
  input  logic [N_PINS-1:0] ext_drv_i,
  output logic [N_PINS-1:0] pad_level_o,
  output logic [N_PINS-1:0] irq_o
);
  localparam int unsigned SYNC_W = 2 * N_PINS;

  logic [N_PINS-1:0] in_en_q, drv_en_q, drv_val_q, pull_q, strength_q, drv_inv_q;
  logic [N_PINS-1:0] rise_en_q, fall_en_q, hi_en_q, lo_en_q, alt_en_q, alt_sel_q;
  logic [N_PINS-1:0] sample_vec, hi_pend, lo_pend, rise_pend, fall_pend;
  logic [N_PINS-1:0] clr_hi, clr_lo, clr_rise, clr_fall;
  logic [N_PINS-1:0] lvl_s, drv_s, wdat;
  logic [SYNC_W-1:0] sync_q;

  assign wdat = bus_wdata_i[N_PINS-1:0];

  gpio_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_drv_i, ext_lvl_i}),
    .q_o   (sync_q)
  );
  assign {drv_s, lvl_s} = sync_q;

  always_comb begin
    clr_hi   = (bus_wr_i && bus_addr_i == OFF_HI_PEND)   ? wdat : '0;
    clr_lo   = (bus_wr_i && bus_addr_i == OFF_LO_PEND)   ? wdat : '0;
    clr_rise = (bus_wr_i && bus_addr_i == OFF_RISE_PEND) ? wdat : '0;
    clr_fall = (bus_wr_i && bus_addr_i == OFF_FALL_PEND) ? wdat : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_en_q    <= '0;
      drv_en_q   <= '0;
      drv_val_q  <= '0;
      pull_q     <= '0;
      strength_q <= '0;
      drv_inv_q  <= '0;
      rise_en_q  <= '0;
      fall_en_q  <= '0;
      hi_en_q    <= '0;
      lo_en_q    <= '0;
      alt_en_q   <= '0;
      alt_sel_q  <= '0;
    end else if (bus_wr_i) begin
      case (bus_addr_i)
        OFF_IN_EN:    in_en_q    <= wdat;
        OFF_DRV_EN:   drv_en_q   <= wdat;
        OFF_DRV_VAL:  drv_val_q  <= wdat;
        OFF_PULL:     pull_q     <= wdat;
        OFF_STRENGTH: strength_q <= wdat;
        OFF_DRV_INV:  drv_inv_q  <= wdat;
        OFF_RISE_EN:  rise_en_q  <= wdat;
        OFF_FALL_EN:  fall_en_q  <= wdat;
        OFF_HI_EN:    hi_en_q    <= wdat;
        OFF_LO_EN:    lo_en_q    <= wdat;
        OFF_ALT_EN:   alt_en_q   <= wdat;
        OFF_ALT_SEL:  alt_sel_q  <= wdat;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic [N_EV-1:0] clr_w, en_w, pend_w;
    assign clr_w[EV_HI]   = clr_hi[i];
    assign clr_w[EV_LO]   = clr_lo[i];
    assign clr_w[EV_RISE] = clr_rise[i];
    assign clr_w[EV_FALL] = clr_fall[i];
    assign en_w[EV_HI]    = hi_en_q[i];
    assign en_w[EV_LO]    = lo_en_q[i];
    assign en_w[EV_RISE]  = rise_en_q[i];
    assign en_w[EV_FALL]  = fall_en_q[i];

    gpio_pin u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ext_drv_i(drv_s[i]),
      .ext_lvl_i(lvl_s[i]),
      .in_en_i  (in_en_q[i]),
      .drv_en_i (drv_en_q[i]),
      .drv_val_i(drv_val_q[i]),
      .drv_inv_i(drv_inv_q[i]),
      .pull_en_i(pull_q[i]),
      .clr_i    (clr_w),
      .ev_en_i  (en_w),
      .level_o  (pad_level_o[i]),
      .sample_o (sample_vec[i]),
      .pend_o   (pend_w),
      .irq_o    (irq_o[i])
    );

    assign hi_pend[i]   = pend_w[EV_HI];
    assign lo_pend[i]   = pend_w[EV_LO];
    assign rise_pend[i] = pend_w[EV_RISE];
    assign fall_pend[i] = pend_w[EV_FALL];
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_SAMPLE:    bus_rdata_o = DATA_W'(sample_vec);
      OFF_IN_EN:     bus_rdata_o = DATA_W'(in_en_q);
      OFF_DRV_EN:    bus_rdata_o = DATA_W'(drv_en_q);
      OFF_DRV_VAL:   bus_rdata_o = DATA_W'(drv_val_q);
      OFF_PULL:      bus_rdata_o = DATA_W'(pull_q);
      OFF_STRENGTH:  bus_rdata_o = DATA_W'(strength_q);
      OFF_RISE_EN:   bus_rdata_o = DATA_W'(rise_en_q);
      OFF_RISE_PEND: bus_rdata_o = DATA_W'(rise_pend);
      OFF_FALL_EN:   bus_rdata_o = DATA_W'(fall_en_q);
      OFF_FALL_PEND: bus_rdata_o = DATA_W'(fall_pend);
      OFF_HI_EN:     bus_rdata_o = DATA_W'(hi_en_q);
      OFF_HI_PEND:   bus_rdata_o = DATA_W'(hi_pend);
      OFF_LO_EN:     bus_rdata_o = DATA_W'(lo_en_q);
      OFF_LO_PEND:   bus_rdata_o = DATA_W'(lo_pend);
      OFF_ALT_EN:    bus_rdata_o = DATA_W'(alt_en_q);
      OFF_ALT_SEL:   bus_rdata_o = DATA_W'(alt_sel_q);
      OFF_DRV_INV:   bus_rdata_o = DATA_W'(drv_inv_q);
      default:       bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N_PINS-1:0] pad_level_o,
  input logic [N_PINS-1:0] irq_o,
  input logic [N_PINS-1:0] in_en_q,
  input logic [N_PINS-1:0] drv_en_q,
  input logic [N_PINS-1:0] drv_val_q,
  input logic [N_PINS-1:0] pull_q,
  input logic [N_PINS-1:0] drv_inv_q,
  input logic [N_PINS-1:0] sample_vec,
  input logic [N_PINS-1:0] hi_pend,
  input logic [N_PINS-1:0] lo_pend,
  input logic [N_PINS-1:0] rise_pend,
  input logic [N_PINS-1:0] fall_pend,
  input logic [N_PINS-1:0] hi_en_q,
  input logic [N_PINS-1:0] lo_en_q,
  input logic [N_PINS-1:0] rise_en_q,
  input logic [N_PINS-1:0] fall_en_q
);
  logic unmapped;
  assign unmapped = (bus_addr_i > OFF_DRV_INV) || (bus_addr_i[1:0] != 2'b00);

  p_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sample_vec == $past(in_en_q & pad_level_o));

  p_hi_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == OFF_HI_PEND) |=> (hi_pend & $past(hi_pend)) == $past(hi_pend));

  p_lo_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (~$past(in_en_q) & ~lo_pend) == '0);

  p_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sample_vec & ~$past(sample_vec)) & ~rise_pend) == '0);

  p_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~sample_vec & $past(sample_vec)) & ~fall_pend) == '0);

  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en_q == '0 && lo_en_q == '0 && rise_en_q == '0 && fall_en_q == '0) |-> irq_o == '0);

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && unmapped) |=> $stable(in_en_q) && $stable(drv_en_q) && $stable(drv_val_q)
                               && $stable(pull_q) && $stable(drv_inv_q) && $stable(hi_en_q)
                               && $stable(lo_en_q) && $stable(rise_en_q) && $stable(fall_en_q));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N_PINS(N_PINS)) u_chk (.*);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ext_lvl = '0, ext_drv = '0;
  logic [31:0] pad_level, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .ext_lvl_i(ext_lvl),
    .ext_drv_i(ext_drv), .pad_level_o(pad_level), .irq_o(irq)
  );

  // reference model state
  logic [31:0] m_in_en, m_drv_en, m_drv_val, m_pull, m_str, m_inv;
  logic [31:0] m_rise_en, m_fall_en, m_hi_en, m_lo_en, m_alt_en, m_alt_sel;
  logic [31:0] m_val, m_hi, m_lo, m_rise, m_fall;
  logic [31:0] m_d1, m_l1, m_d2, m_l2;

  function automatic logic [31:0] exp_pad();
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (m_d2[i])          r[i] = m_l2[i];
      else if (m_drv_en[i]) r[i] = m_drv_val[i] ^ m_inv[i];
      else                  r[i] = m_pull[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_irq();
    return (m_hi & m_hi_en) | (m_lo & m_lo_en) | (m_rise & m_rise_en) | (m_fall & m_fall_en);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [6:0] a);
    case (a)
      7'h00: return m_val;     7'h04: return m_in_en;   7'h08: return m_drv_en;
      7'h0C: return m_drv_val; 7'h10: return m_pull;    7'h14: return m_str;
      7'h18: return m_rise_en; 7'h1C: return m_rise;    7'h20: return m_fall_en;
      7'h24: return m_fall;    7'h28: return m_hi_en;   7'h2C: return m_hi;
      7'h30: return m_lo_en;   7'h34: return m_lo;      7'h38: return m_alt_en;
      7'h3C: return m_alt_sel; 7'h40: return m_inv;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [6:0] a);
    case (a)
      7'h00: return "R3 sample read";
      7'h1C, 7'h24: return "R5/R6 edge flag read";
      7'h2C, 7'h34: return "R4/R6 level flag read";
      7'h14, 7'h38, 7'h3C: return "R10 storage read";
      default: return "R9 register read";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_in_en, m_drv_en, m_drv_val, m_pull, m_str, m_inv} = '0;
      {m_rise_en, m_fall_en, m_hi_en, m_lo_en, m_alt_en, m_alt_sel} = '0;
      {m_val, m_hi, m_lo, m_rise, m_fall, m_d1, m_l1, m_d2, m_l2} = '0;
    end else begin
      logic [31:0] iv, c;
      iv = m_in_en & exp_pad();
      c = bus_wr ? bus_wdata : 32'h0;
      m_hi   = (m_hi   & ~((bus_addr == 7'h2C) ? c : 32'h0)) | iv;
      m_lo   = (m_lo   & ~((bus_addr == 7'h34) ? c : 32'h0)) | ~iv;
      m_rise = (m_rise & ~((bus_addr == 7'h1C) ? c : 32'h0)) | (iv & ~m_val);
      m_fall = (m_fall & ~((bus_addr == 7'h24) ? c : 32'h0)) | (~iv & m_val);
      m_val  = iv;
      if (bus_wr) begin
        case (bus_addr)
          7'h04: m_in_en = bus_wdata;   7'h08: m_drv_en = bus_wdata;
          7'h0C: m_drv_val = bus_wdata; 7'h10: m_pull = bus_wdata;
          7'h14: m_str = bus_wdata;     7'h18: m_rise_en = bus_wdata;
          7'h20: m_fall_en = bus_wdata; 7'h28: m_hi_en = bus_wdata;
          7'h30: m_lo_en = bus_wdata;   7'h38: m_alt_en = bus_wdata;
          7'h3C: m_alt_sel = bus_wdata; 7'h40: m_inv = bus_wdata;
          default: ;
        endcase
      end
      m_d2 = m_d1; m_l2 = m_l1;
      m_d1 = ext_drv; m_l1 = ext_lvl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R1/R2 pad level", pad_level, exp_pad());
    chk("R7 irq lines", irq, exp_irq());
    chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a);
    bus_addr = a;
    tick();
  endtask

  initial begin
    logic [31:0] pad_keep, smp_keep;
    repeat (2) tick();
    for (int k = 0; k <= 16; k++) begin
      rd(7'(k * 4));
      chk("R8 register zero in reset", bus_rdata, 32'h0);
    end
    chk("R8 irq zero in reset", irq, 32'h0);

    rst_n = 1'b1;
    rd(7'h34);
    chk("R4 low flags set with input off", bus_rdata, 32'hFFFF_FFFF);

    wr(7'h08, 32'h0000_000F);
    wr(7'h0C, 32'h0000_0005);
    wr(7'h40, 32'h0000_0003);
    tick();
    chk("R1 driven xor invert", pad_level & 32'hF, 32'h6);
    wr(7'h10, 32'h0000_00F0);
    chk("R2 pull as idle level", pad_level & 32'hFF, 32'hF6);

    ext_drv = 32'h0000_0102; ext_lvl = 32'h0000_0100;
    tick();
    chk("R3 external not yet through sync", pad_level & 32'h1FF, 32'h0F6);
    tick();
    chk("R2 external claim wins", pad_level & 32'h1FF, 32'h1F4);

    wr(7'h04, 32'hFFFF_FFFF);
    rd(7'h00);
    chk("R3 sample register", bus_rdata, 32'h0000_01F4);

    wr(7'h34, 32'hFFFF_FFFF);
    rd(7'h34);
    chk("R6 clear low flags", bus_rdata, 32'hFFFF_FE0B);
    rd(7'h2C);
    chk("R4 high flags sticky", bus_rdata, 32'h0000_01F4);
    rd(7'h1C);
    chk("R5 rise flags", bus_rdata, 32'h0000_01F4);
    wr(7'h1C, 32'h0000_000F);
    rd(7'h1C);
    chk("R6 partial clear", bus_rdata, 32'h0000_01F0);

    wr(7'h18, 32'h0000_0010);
    chk("R7 enabled rise raises irq", irq, 32'h0000_0010);
    wr(7'h1C, 32'h0000_0010);
    chk("R7 irq drops after clear", irq, 32'h0);

    ext_lvl = 32'h0;
    repeat (3) tick();
    rd(7'h24);
    chk("R5 fall flag", bus_rdata, 32'h0000_0100);

    wr(7'h34, 32'h0000_0100);
    rd(7'h34);
    chk("R6 set wins over clear", bus_rdata & 32'h100, 32'h100);

    pad_keep = pad_level;
    wr(7'h14, 32'hFFFF_FFFF);
    wr(7'h38, 32'hFFFF_FFFF);
    wr(7'h3C, 32'hA5A5_A5A5);
    tick();
    chk("R10 pad unaffected by storage regs", pad_level, pad_keep);
    rd(7'h3C);
    chk("R10 alt select read back", bus_rdata, 32'hA5A5_A5A5);

    wr(7'h44, 32'h1234_5678);
    wr(7'h05, 32'h0);
    rd(7'h44);
    chk("R9 unmapped reads zero", bus_rdata, 32'h0);
    rd(7'h04);
    chk("R9 unaligned write ignored", bus_rdata, 32'hFFFF_FFFF);

    rd(7'h00);
    smp_keep = bus_rdata;
    wr(7'h00, ~smp_keep);
    rd(7'h00);
    chk("R11 sample write ignored", bus_rdata, smp_keep);

    for (int n = 0; n < 600; n++) begin
      ext_lvl = $urandom();
      ext_drv = $urandom();
      if ($urandom_range(0, 1) == 0) begin
        bus_wr = 1'b1;
        bus_addr = 7'($urandom_range(0, 17) * 4);
        bus_wdata = $urandom();
      end else begin
        bus_wr = 1'b0;
        bus_addr = 7'($urandom_range(0, 17) * 4);
      end
      tick();
    end
    bus_wr = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule